// File: doc/BRIEF.md
# Flash Page-Program Command Sequencer

This block drives one protected page write into a byte-wide flash device that sits behind an asynchronous bus engine. A single start pulse makes it issue the three command writes that unlock the device and put it into program mode. It then moves one full 128-byte sector from a host byte port onto the bus at consecutive addresses, and finally reads the last programmed location over and over until bit 7 of the returned byte equals bit 7 of the byte written there.

The bus engine owns all strobe timing. The sequencer only raises a request with an address, a direction and write data, and it holds them until the engine returns a one-cycle acknowledge. A read acknowledge carries the data. The host port is a valid/ready byte handshake. When the host has no byte ready, the sector waits with no bus traffic and is never cut short. A programmable limit, counted in clock ticks from the first polling cycle, ends a write cycle that never completes. Busy, done, timeout and a sticky misuse flag give the result.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o, err_o, bus_req_o and hd_ready_o are all low.
- R2: An accepted start produces exactly three bus writes before any data: value 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555.
- R3: Exactly 128 data writes follow the commands. They start at base_addr_i with its low 7 bits cleared and step by one address per byte, so the last write goes to the aligned base plus 127.
- R4: A host byte transfers on a cycle where hd_valid_i and hd_ready_o are both high. hd_ready_o is high only while the sequencer waits for the next sector byte, and it is never high together with bus_req_o. Bytes offered while idle are not consumed. A stalled host pauses the sector without ending it.
- R5: Once bus_req_o is raised, it stays high with unchanged address, direction and write data until bus_ack_i is seen. The only exception is the cycle in which a timeout ends the sequence.
- R6: After the last data write, the sequencer issues repeated reads of the last programmed address. The first read whose bit 7 equals bit 7 of the last written byte sets done_o and clears busy_o. No further reads follow.
- R7: Let T be the timeout_i value latched at start. If no matching read has completed by the end of polling cycle T, counting from cycle 0, then timeout_o is set and busy_o clears. A matching read that completes in cycle T counts as done.
- R8: A start_i pulse while busy_o is high is ignored and sets err_o, which stays set. An accepted start clears err_o, done_o and timeout_o.
- R9: done_o and timeout_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one page program |
| base_addr_i | input | ADDR_W | Sector address, aligned down internally |
| timeout_i | input | TO_W | Poll limit in ticks, latched at start |
| hd_valid_i | input | 1 | Host byte available |
| hd_data_i | input | DATA_W | Host byte |
| hd_ready_o | output | 1 | Sequencer takes a byte this cycle if valid |
| bus_req_o | output | 1 | Bus engine request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_ack_i | input | 1 | One-cycle completion from bus engine |
| bus_rdata_i | input | DATA_W | Read data, valid with bus_ack_i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence completed by status match |
| timeout_o | output | 1 | Last sequence ended by poll limit |
| err_o | output | 1 | Sticky: start seen while busy |

## Verification
Two functions can land in the same cycle: the completion of a matching status read and the expiry of the poll limit. The bench fixes the bus latency at one cycle and makes the first two status reads return a mismatching bit 7. This places the third, matching acknowledge in polling cycle 8. A run with limit 8 must end in done and a run with limit 7 must end in timeout. A start pulse injected while a sector is streaming is judged by err_o and by a bus log that still holds exactly one command-and-sector sequence.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CMD   = 3'd1,
      ST_FETCH = 3'd2,
      ST_WRITE = 3'd3,
      ST_POLL  = 3'd4
   } fpg_state_e;

   localparam int unsigned UNLOCK_STEPS = 3;

endpackage

// File: rtl/fpg_cmd_table.sv
module fpg_cmd_table #(
   parameter int unsigned ADDR_W       = 17,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CMD_ADDR_A   = 32'h5555,
   parameter int unsigned CMD_ADDR_B   = 32'h2AAA,
   parameter int unsigned CMD_UNLOCK_1 = 32'hAA,
   parameter int unsigned CMD_UNLOCK_2 = 32'h55,
   parameter int unsigned CMD_PROGRAM  = 32'hA0
) (
   input  logic [1:0]        step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);

   localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(CMD_ADDR_A);
   localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(CMD_ADDR_B);

   always_comb begin
      case (step_i)
         2'd0: begin
            addr_o = A_FIRST;
            data_o = DATA_W'(CMD_UNLOCK_1);
         end
         2'd1: begin
            addr_o = A_SECOND;
            data_o = DATA_W'(CMD_UNLOCK_2);
         end
         default: begin
            addr_o = A_FIRST;
            data_o = DATA_W'(CMD_PROGRAM);
         end
      endcase
   end

endmodule

// File: rtl/fpg_sector_ctr.sv
module fpg_sector_ctr #(
   parameter int unsigned ADDR_W     = 17,
   parameter int unsigned SECT_BYTES = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);

   localparam int unsigned      OFS_W    = $clog2(SECT_BYTES);
   localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(SECT_BYTES - 1);
   localparam logic [OFS_W-1:0]  OFS_LAST = OFS_W'(SECT_BYTES - 1);

   logic [ADDR_W-1:0] page_q;
   logic [OFS_W-1:0]  ofs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         ofs_q  <= '0;
      end else if (load_i) begin
         page_q <= base_i & ~OFS_MASK;
         ofs_q  <= '0;
      end else if (adv_i) begin
         ofs_q  <= ofs_q + 1'b1;
      end
   end

   assign addr_o = page_q | ADDR_W'(ofs_q);
   assign last_o = (ofs_q == OFS_LAST);

   // R3: the sequencer never steps past the final byte of the sector
   a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !(adv_i && last_o));

endmodule

// File: rtl/fpg_poll_timer.sv
module fpg_poll_timer #(
   parameter int unsigned TO_W     = 24,
   parameter int unsigned PRESCALE = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [TO_W-1:0] limit_i,
   input  logic            run_i,
   output logic            expired_o
);

   logic            tick;
   logic [TO_W-1:0] cnt_q;

   if (PRESCALE <= 1) begin : g_direct
      assign tick = run_i;
   end else begin : g_scaled
      localparam int unsigned PS_W = $clog2(PRESCALE);
      logic [PS_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pre_q <= '0;
         else if (load_i || !run_i)
            pre_q <= '0;
         else if (pre_q == PS_W'(PRESCALE - 1))
            pre_q <= '0;
         else
            pre_q <= pre_q + 1'b1;
      end
      assign tick = run_i && (pre_q == PS_W'(PRESCALE - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= limit_i;
      else if (tick && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = run_i && (cnt_q == '0);

   // R7: while polling, the remaining limit only ever shrinks
   a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $past(run_i) && !$past(load_i)) |-> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
   import flash_pgm_pkg::*;
#(
   parameter int unsigned ADDR_W       = 17,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned SECT_BYTES   = 128,
   parameter int unsigned TO_W         = 24,
   parameter int unsigned PRESCALE     = 1,
   parameter int unsigned POLL_BIT     = 7,
   parameter int unsigned CMD_ADDR_A   = 32'h5555,
   parameter int unsigned CMD_ADDR_B   = 32'h2AAA,
   parameter int unsigned CMD_UNLOCK_1 = 32'hAA,
   parameter int unsigned CMD_UNLOCK_2 = 32'h55,
   parameter int unsigned CMD_PROGRAM  = 32'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [TO_W-1:0]   timeout_i,
   input  logic              hd_valid_i,
   input  logic [DATA_W-1:0] hd_data_i,
   output logic              hd_ready_o,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic              bus_ack_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              timeout_o,
   output logic              err_o
);

   localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(1) << POLL_BIT;
   localparam logic [1:0]        STEP_LAST = 2'(UNLOCK_STEPS - 1);

   // elaboration-time parameter checks
   if ((SECT_BYTES < 2) || ((SECT_BYTES & (SECT_BYTES - 1)) != 0)) begin : g_bad_sect
      $error("SECT_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= $clog2(SECT_BYTES)) begin : g_bad_addr
      $error("ADDR_W too small for one sector");
   end
   if ((ADDR_W < 32) && ((CMD_ADDR_A >= (32'd1 << ADDR_W)) || (CMD_ADDR_B >= (32'd1 << ADDR_W)))) begin : g_bad_cmd
      $error("command addresses do not fit ADDR_W");
   end
   if (POLL_BIT >= DATA_W) begin : g_bad_bit
      $error("POLL_BIT outside data width");
   end
   if ((PRESCALE < 1) || (TO_W < 1)) begin : g_bad_timer
      $error("PRESCALE and TO_W must be at least 1");
   end

   fpg_state_e        state_q, state_d;
   logic [1:0]        step_q, step_d;
   logic [DATA_W-1:0] wbyte_q;
   logic [TO_W-1:0]   lim_q;
   logic              done_q, to_q, err_q;

   logic [ADDR_W-1:0] cmd_addr, sect_addr;
   logic [DATA_W-1:0] cmd_data;
   logic              sect_last, sect_adv;
   logic              tmr_load, tmr_expired;
   logic              start_acc, poll_match, take_byte;

   assign start_acc  = start_i && (state_q == ST_IDLE);
   assign take_byte  = (state_q == ST_FETCH) && hd_valid_i;
   assign poll_match = ((bus_rdata_i ^ wbyte_q) & POLL_MASK) == '0;
   assign sect_adv   = (state_q == ST_WRITE) && bus_ack_i && !sect_last;
   assign tmr_load   = (state_q == ST_WRITE) && bus_ack_i && sect_last;

   fpg_cmd_table #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .CMD_ADDR_A  (CMD_ADDR_A),
      .CMD_ADDR_B  (CMD_ADDR_B),
      .CMD_UNLOCK_1(CMD_UNLOCK_1),
      .CMD_UNLOCK_2(CMD_UNLOCK_2),
      .CMD_PROGRAM (CMD_PROGRAM)
   ) u_cmd (
      .step_i(step_q),
      .addr_o(cmd_addr),
      .data_o(cmd_data)
   );

   fpg_sector_ctr #(
      .ADDR_W    (ADDR_W),
      .SECT_BYTES(SECT_BYTES)
   ) u_sect (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(start_acc),
      .base_i(base_addr_i),
      .adv_i (sect_adv),
      .addr_o(sect_addr),
      .last_o(sect_last)
   );

   fpg_poll_timer #(
      .TO_W    (TO_W),
      .PRESCALE(PRESCALE)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_load),
      .limit_i  (lim_q),
      .run_i    (state_q == ST_POLL),
      .expired_o(tmr_expired)
   );

   always_comb begin
      state_d = state_q;
      step_d  = step_q;
      case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_CMD;
               step_d  = '0;
            end
         end
         ST_CMD: begin
            if (bus_ack_i) begin
               if (step_q == STEP_LAST)
                  state_d = ST_FETCH;
               else
                  step_d = step_q + 1'b1;
            end
         end
         ST_FETCH: begin
            if (hd_valid_i)
               state_d = ST_WRITE;
         end
         ST_WRITE: begin
            if (bus_ack_i)
               state_d = sect_last ? ST_POLL : ST_FETCH;
         end
         ST_POLL: begin
            if ((bus_ack_i && poll_match) || tmr_expired)
               state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         wbyte_q <= '0;
         lim_q   <= '0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
         if (take_byte)
            wbyte_q <= hd_data_i;
         if (start_acc)
            lim_q <= timeout_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         to_q   <= 1'b0;
         err_q  <= 1'b0;
      end else if (start_acc) begin
         done_q <= 1'b0;
         to_q   <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (start_i)
            err_q <= 1'b1;
         if (state_q == ST_POLL) begin
            if (bus_ack_i && poll_match)
               done_q <= 1'b1;
            else if (tmr_expired)
               to_q <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_req_o   = 1'b0;
      bus_we_o    = 1'b0;
      bus_addr_o  = '0;
      bus_wdata_o = '0;
      case (state_q)
         ST_CMD: begin
            bus_req_o   = 1'b1;
            bus_we_o    = 1'b1;
            bus_addr_o  = cmd_addr;
            bus_wdata_o = cmd_data;
         end
         ST_WRITE: begin
            bus_req_o   = 1'b1;
            bus_we_o    = 1'b1;
            bus_addr_o  = sect_addr;
            bus_wdata_o = wbyte_q;
         end
         ST_POLL: begin
            bus_req_o   = 1'b1;
            bus_addr_o  = sect_addr;
            bus_wdata_o = wbyte_q;
         end
         default: ;
      endcase
   end

   assign hd_ready_o = (state_q == ST_FETCH);
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign timeout_o  = to_q;
   assign err_o      = err_q;

   // R5: a pending request holds its fields until acknowledged or abandoned on timeout
   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i) |=> ((bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)
                                      && $stable(bus_wdata_o)) || timeout_o));

   // R4: the host port and the bus are never active together
   a_r4_ready_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      hd_ready_o |-> !bus_req_o);

   // R9: exclusive completion flags
   a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && timeout_o));

   // R6: completion leaves the sequencer idle
   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> !busy_o);

   // R8: the misuse flag stays set until a start is accepted
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !(start_i && !busy_o)) |=> err_o);

endmodule

// File: tb/tb_flash_page_prog.sv
module tb_flash_page_prog;

   localparam int AW = 17;
   localparam int DW = 8;
   localparam int SB = 128;
   localparam int TW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] base = '0;
   logic [TW-1:0] tmo = '0;
   logic          hvalid = 1'b0;
   logic [DW-1:0] hdata = '0;
   logic          hready;
   logic          req, we, ack;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, rdata;
   logic          busy, done, tout, err;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   flash_page_prog dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base), .timeout_i(tmo),
      .hd_valid_i(hvalid), .hd_data_i(hdata), .hd_ready_o(hready),
      .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
      .bus_ack_i(ack), .bus_rdata_i(rdata),
      .busy_o(busy), .done_o(done), .timeout_o(tout), .err_o(err)
   );

   // ---------------- bus engine + flash model ----------------
   int            lat = 0;
   int            busy_reads = 0;
   logic          clr = 1'b0;
   int            cnt = 0;
   int            wr_n = 0;
   int            rd_n = 0;
   int            rd_bad = 0;
   int            hold_viol = 0;
   logic [AW-1:0] exp_last = '0;
   logic [AW-1:0] log_a [0:255];
   logic [DW-1:0] log_d [0:255];
   logic [DW-1:0] last_wr = '0;
   logic          pend = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic [DW-1:0] p_wd = '0;
   logic          p_we = 1'b0;

   initial ack = 1'b0;
   initial rdata = '0;

   always @(posedge clk) begin
      ack <= 1'b0;
      if (clr) begin
         cnt <= 0; wr_n <= 0; rd_n <= 0; rd_bad <= 0; hold_viol <= 0; pend <= 1'b0;
      end else if (req && !ack) begin
         if (pend && (addr != p_addr || we != p_we || wdata != p_wd))
            hold_viol <= hold_viol + 1;
         p_addr <= addr; p_we <= we; p_wd <= wdata;
         if (cnt >= lat) begin
            ack  <= 1'b1;
            cnt  <= 0;
            pend <= 1'b0;
            if (we) begin
               if (wr_n < 256) begin
                  log_a[wr_n] <= addr;
                  log_d[wr_n] <= wdata;
               end
               wr_n    <= wr_n + 1;
               last_wr <= wdata;
            end else begin
               if (addr != exp_last) rd_bad <= rd_bad + 1;
               rd_n  <= rd_n + 1;
               rdata <= (rd_n < busy_reads) ? (last_wr ^ 8'hA5) : last_wr;
            end
         end else begin
            cnt  <= cnt + 1;
            pend <= 1'b1;
         end
      end else if (!req) begin
         cnt  <= 0;
         pend <= 1'b0;
      end
   end

   // ---------------- helpers ----------------
   function automatic logic [DW-1:0] pat(input int run, input int i);
      return DW'(i * 37 + run * 11 + 3);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic feed(input int run, input int gap);
      for (int i = 0; i < SB; i++) begin
         hvalid = 1'b0;
         repeat (gap) @(negedge clk);
         hvalid = 1'b1;
         hdata  = pat(run, i);
         while (!hready) @(negedge clk);
         @(negedge clk);
      end
      hvalid = 1'b0;
   endtask

   task automatic wait_idle();
      int k;
      k = 0;
      while (busy && k < 40000) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic run_prog(input int run, input logic [AW-1:0] b, input int t, input int l,
                           input int br, input int gap, input bit exp_done, input bit poke);
      logic [AW-1:0] abase;
      int nbad_a, nbad_d;
      abase = b & ~AW'(SB - 1);
      @(negedge clk);
      clr = 1'b1; lat = l; busy_reads = br; base = b; tmo = TW'(t);
      exp_last = abase + AW'(SB - 1);
      @(negedge clk);
      clr = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && !done && !tout && !err, "R8", {busy, done, tout, err}, 4'b1000, "flags after accepted start");
      fork
         feed(run, gap);
         wait_idle();
         if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
      join
      repeat (3) @(negedge clk);
      chk(!busy, "R6", busy, 0, "busy after sequence");
      chk(done == exp_done && tout == !exp_done, exp_done ? "R6" : "R7",
          {done, tout}, exp_done ? 2 : 1, "done/timeout outcome");
      chk(!(done && tout), "R9", {done, tout}, 0, "outcome exclusive");
      chk(wr_n == 3 + SB, "R3", wr_n, 3 + SB, "write count");
      chk(log_a[0] == AW'(17'h5555) && log_d[0] == 8'hAA, "R2", log_d[0], 8'hAA, "command 1");
      chk(log_a[1] == AW'(17'h2AAA) && log_d[1] == 8'h55, "R2", log_d[1], 8'h55, "command 2");
      chk(log_a[2] == AW'(17'h5555) && log_d[2] == 8'hA0, "R2", log_d[2], 8'hA0, "command 3");
      nbad_a = 0; nbad_d = 0;
      for (int i = 0; i < SB; i++) begin
         if (log_a[3 + i] != abase + AW'(i)) nbad_a++;
         if (log_d[3 + i] != pat(run, i)) nbad_d++;
      end
      chk(nbad_a == 0, "R3", nbad_a, 0, "sector address mismatches");
      chk(nbad_d == 0, "R4", nbad_d, 0, "sector byte mismatches");
      chk(hold_viol == 0, "R5", hold_viol, 0, "request changed while pending");
      chk(rd_bad == 0, "R6", rd_bad, 0, "poll reads at wrong address");
      if (exp_done)
         chk(rd_n == br + 1, "R6", rd_n, br + 1, "status reads issued");
      chk(err == poke, "R8", err, poke, "start while busy flag");
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !tout && !err, "R1", {busy, done, tout, err}, 0, "status after reset");
      chk(!req && !hready, "R1", {req, hready}, 0, "bus and host idle after reset");

      // R4: bytes offered while idle are not taken and cause no bus traffic
      hvalid = 1'b1; hdata = 8'h3C;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(!hready && !req, "R4", {hready, req}, 0, "idle ignores host byte");
      end
      hvalid = 1'b0;
      chk(wr_n == 0, "R4", wr_n, 0, "no writes while idle");

      // basic page, zero latency, first poll matches
      run_prog(1, 17'h01234, 1000, 0, 0, 0, 1'b1, 1'b0);
      // top sector, host stalls, slow bus, several busy polls
      run_prog(2, 17'h1FFFF, 5000, 2, 5, 3, 1'b1, 1'b0);
      // R7 boundary: matching read lands in the expiry cycle -> done
      run_prog(3, 17'h00080, 8, 1, 2, 0, 1'b1, 1'b0);
      // R7 boundary: one cycle shorter -> timeout
      run_prog(4, 17'h00500, 7, 1, 2, 1, 1'b0, 1'b0);
      // R7: device never finishes
      run_prog(5, 17'h0ABCD, 50, 0, 100000, 0, 1'b0, 1'b0);
      // R8: start while streaming is ignored and flagged
      run_prog(6, 17'h12345, 1000, 1, 1, 2, 1'b1, 1'b1);
      // R8: next accepted start clears the flag (checked inside), normal result
      run_prog(7, 17'h00000, 1000, 0, 3, 0, 1'b1, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule